// File: doc/BRIEF.md
# DMA Channel Register Controller

This block is the register and interrupt-status front end of a multi-channel DMA layer. Software reaches it through a simple register bus: a write strobe with a 10-bit word address and 32-bit data, and a read data output that follows the address in the same cycle. The block holds the global configuration, an error status word, the interrupt enables, the active masks of the transmit and receive channels, the end-of-buffer and descriptor-error status words, and per-channel descriptor table pointers and receive buffer sizes.

The data movers and the descriptor fetch logic sit outside the block. They report events as single-cycle pulses on the event inputs. Those pulses set status bits, and the block combines the status bits with the enables into four interrupt lines. The transmit and receive channel counts are parameters, each from 1 to 32.

Top module: `dma_chan_regs`

## Requirements
- R1: After hard reset (rstN low), config reads 0x0007C000. The error, enable, active, end-of-buffer and descriptor-error registers, every descriptor pointer and every buffer size read 0, and all four irq lines are low.
- R2: A config write (address 0x180) with data bit 31 clear stores the data ANDed with 0x00FFC087.
- R3: A config write with data bit 31 set is a soft reset. From the next cycle, config reads 0x0007C000, and the error, enable, active, end-of-buffer and descriptor-error registers read 0. Any event pulse in that same cycle is dropped. Descriptor pointers and buffer sizes keep their values.
- R4: The interrupt enable register (0x182) keeps only data bits 4:0. The bits are: bit0 transmit end-of-buffer, bit1 receive end-of-buffer, bit2 transmit descriptor error, bit3 error status, bit4 receive descriptor error.
- R5: Transmit channel c is active bit 31-c. Only the top TX_CH bits exist. Writing ones to 0x188 sets those active bits and writing ones to 0x189 clears them. The receive mask uses 0x18A (set) and 0x18B (clear) with RX_CH bits. Reading either address of a pair returns the current mask.
- R6: Channel c maps to status bit c in the end-of-buffer status registers (transmit 0x18C, receive 0x18D) and the descriptor-error status registers (transmit 0x18E, receive 0x18F). An event pulse sets the bit. Writing a one clears it. If a clear and an event hit the same bit in the same cycle, the bit stays set.
- R7: irq[0] is the OR of the transmit end-of-buffer bits gated by enable bit0. irq[1] is the OR of the receive end-of-buffer bits gated by bit1. irq[2] is (transmit descriptor errors AND bit2) OR (receive descriptor errors AND bit4). irq[3] is the OR of the error status gated by bit3. An enabled event raises its irq the cycle after the pulse.
- R8: The transmit pointer of channel c is at 0x1A0+c and the receive pointer of channel c is at 0x1C0+c. Each holds all 32 bits. The receive buffer size of channel c is at 0x1E0+c and keeps only bits 7:0.
- R9: A pointer or buffer-size address whose channel index is at or above the channel count ignores writes and reads 0. Any unmapped address reads 0.
- R10: The error status register (0x181) is ERR_BITS wide. It is set by the errEvt pulses and cleared bit by bit by writing ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hard reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 10 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, same cycle |
| txEobEvt | input | TX_CH | Transmit end-of-buffer event pulses |
| txDerrEvt | input | TX_CH | Transmit descriptor-error event pulses |
| rxEobEvt | input | RX_CH | Receive end-of-buffer event pulses |
| rxDerrEvt | input | RX_CH | Receive descriptor-error event pulses |
| errEvt | input | ERR_BITS | Error status event pulses |
| irq | output | 4 | Interrupt lines |

## Verification
The bench builds the block with TX_CH=4, RX_CH=2 and ERR_BITS=8. With these values the active masks fill only bits 31:28 and 31:30, which makes the discarded low bits of set and clear writes visible. Most of each 32-entry pointer window and buffer-size window lies above the channel count, so random and directed accesses land on indices that must be ignored. Small status widths also make it common for a random clear to meet an event on the same bit in the same cycle.

// File: rtl/dmaregs_pkg.sv
`timescale 1ns/1ps
package dmaregs_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int MAX_CH = 32;
  localparam int IEN_W  = 5;

  localparam logic [ADDR_W-1:0] A_CFG    = 10'h180;
  localparam logic [ADDR_W-1:0] A_ERR    = 10'h181;
  localparam logic [ADDR_W-1:0] A_IEN    = 10'h182;
  localparam logic [ADDR_W-1:0] A_TXSET  = 10'h188;
  localparam logic [ADDR_W-1:0] A_TXCLR  = 10'h189;
  localparam logic [ADDR_W-1:0] A_RXSET  = 10'h18A;
  localparam logic [ADDR_W-1:0] A_RXCLR  = 10'h18B;
  localparam logic [ADDR_W-1:0] A_TXEOB  = 10'h18C;
  localparam logic [ADDR_W-1:0] A_RXEOB  = 10'h18D;
  localparam logic [ADDR_W-1:0] A_TXDERR = 10'h18E;
  localparam logic [ADDR_W-1:0] A_RXDERR = 10'h18F;

  // upper five address bits select a 32-word window
  localparam logic [4:0] WIN_FIXED = 5'h0C;
  localparam logic [4:0] WIN_TXPTR = 5'h0D;
  localparam logic [4:0] WIN_RXPTR = 5'h0E;
  localparam logic [4:0] WIN_RXBS  = 5'h0F;

  localparam logic [DATA_W-1:0] CFG_RESET = 32'h0007_C000;
  localparam logic [DATA_W-1:0] CFG_KEEP  = 32'h00FF_C087;

  typedef enum logic [3:0] {
    RD_NONE, RD_CFG, RD_ERR, RD_IEN, RD_TXACT, RD_RXACT,
    RD_TXEOB, RD_RXEOB, RD_TXDERR, RD_RXDERR,
    RD_TXPTR, RD_RXPTR, RD_RXBS
  } rdSel_e;

  typedef struct packed {
    logic       cfgWr;
    logic       softRst;
    logic       errClr;
    logic       ienWr;
    logic       txSet;
    logic       txClr;
    logic       rxSet;
    logic       rxClr;
    logic       txEobClr;
    logic       rxEobClr;
    logic       txDerrClr;
    logic       rxDerrClr;
    logic       txPtrWr;
    logic       rxPtrWr;
    logic       rxBsWr;
    logic [4:0] chan;
    rdSel_e     rdSel;
  } strobes_t;
endpackage

// File: rtl/dmaregs_decode.sv
`timescale 1ns/1ps
module dmaregs_decode
  import dmaregs_pkg::*;
#(
  parameter int TX_CH = 4,
  parameter int RX_CH = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output strobes_t          stb
);
  localparam logic [5:0] TX_LIM = 6'(TX_CH);
  localparam logic [5:0] RX_LIM = 6'(RX_CH);

  logic [4:0] win;
  logic       txOk;
  logic       rxOk;

  assign win  = regAddr[9:5];
  assign txOk = {1'b0, regAddr[4:0]} < TX_LIM;
  assign rxOk = {1'b0, regAddr[4:0]} < RX_LIM;

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    stb.chan  = regAddr[4:0];
    case (win)
      WIN_FIXED: begin
        case (regAddr)
          A_CFG: begin
            stb.rdSel   = RD_CFG;
            stb.cfgWr   = regWrEn && !regWrData[31];
            stb.softRst = regWrEn && regWrData[31];
          end
          A_ERR:    begin stb.rdSel = RD_ERR;    stb.errClr    = regWrEn; end
          A_IEN:    begin stb.rdSel = RD_IEN;    stb.ienWr     = regWrEn; end
          A_TXSET:  begin stb.rdSel = RD_TXACT;  stb.txSet     = regWrEn; end
          A_TXCLR:  begin stb.rdSel = RD_TXACT;  stb.txClr     = regWrEn; end
          A_RXSET:  begin stb.rdSel = RD_RXACT;  stb.rxSet     = regWrEn; end
          A_RXCLR:  begin stb.rdSel = RD_RXACT;  stb.rxClr     = regWrEn; end
          A_TXEOB:  begin stb.rdSel = RD_TXEOB;  stb.txEobClr  = regWrEn; end
          A_RXEOB:  begin stb.rdSel = RD_RXEOB;  stb.rxEobClr  = regWrEn; end
          A_TXDERR: begin stb.rdSel = RD_TXDERR; stb.txDerrClr = regWrEn; end
          A_RXDERR: begin stb.rdSel = RD_RXDERR; stb.rxDerrClr = regWrEn; end
          default:  stb.rdSel = RD_NONE;
        endcase
      end
      WIN_TXPTR: if (txOk) begin stb.rdSel = RD_TXPTR; stb.txPtrWr = regWrEn; end
      WIN_RXPTR: if (rxOk) begin stb.rdSel = RD_RXPTR; stb.rxPtrWr = regWrEn; end
      WIN_RXBS:  if (rxOk) begin stb.rdSel = RD_RXBS;  stb.rxBsWr  = regWrEn; end
      default:   stb.rdSel = RD_NONE;
    endcase
  end

  // at most one register strobe per access
  always_comb begin
    assert ($onehot0({stb.cfgWr, stb.softRst, stb.errClr, stb.ienWr, stb.txSet,
                      stb.txClr, stb.rxSet, stb.rxClr, stb.txEobClr, stb.rxEobClr,
                      stb.txDerrClr, stb.rxDerrClr, stb.txPtrWr, stb.rxPtrWr,
                      stb.rxBsWr}))
      else $error("p_single_strobe_r9");
  end
endmodule

// File: rtl/dmaregs_w1c.sv
`timescale 1ns/1ps
module dmaregs_w1c #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         softRst,
  input  logic         clrEn,
  input  logic [W-1:0] clrMask,
  input  logic [W-1:0] setEvt,
  output logic [W-1:0] q
);
  logic [W-1:0] clrBits;
  assign clrBits = clrEn ? clrMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN || softRst) q <= '0;
    else                  q <= (q & ~clrBits) | setEvt;
  end

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!softRst && setEvt != '0) |=> ((q & $past(setEvt)) == $past(setEvt)));

  p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && !softRst) |=> ((q & $past(clrMask & ~setEvt)) == '0));
endmodule

// File: rtl/dmaregs_datapath.sv
`timescale 1ns/1ps
module dmaregs_datapath
  import dmaregs_pkg::*;
#(
  parameter int TX_CH    = 4,
  parameter int RX_CH    = 2,
  parameter int ERR_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [TX_CH-1:0]    txEobEvt,
  input  logic [TX_CH-1:0]    txDerrEvt,
  input  logic [RX_CH-1:0]    rxEobEvt,
  input  logic [RX_CH-1:0]    rxDerrEvt,
  input  logic [ERR_BITS-1:0] errEvt,
  output logic [DATA_W-1:0]   regRdData,
  output logic [3:0]          irq
);
  logic [DATA_W-1:0]   cfgQ;
  logic [IEN_W-1:0]    ienQ;
  logic [TX_CH-1:0]    txActQ, txActWr;
  logic [RX_CH-1:0]    rxActQ, rxActWr;
  logic [TX_CH-1:0]    txEobQ, txDerrQ;
  logic [RX_CH-1:0]    rxEobQ, rxDerrQ;
  logic [ERR_BITS-1:0] errQ;
  logic [DATA_W-1:0]   txPtr [MAX_CH];
  logic [DATA_W-1:0]   rxPtr [MAX_CH];
  logic [7:0]          rxBs  [MAX_CH];

  // active masks: channel c lives at word bit 31-c
  for (genvar c = 0; c < TX_CH; c++) begin : g_txActMap
    assign txActWr[c] = regWrData[DATA_W-1-c];
  end
  for (genvar c = 0; c < RX_CH; c++) begin : g_rxActMap
    assign rxActWr[c] = regWrData[DATA_W-1-c];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.softRst) begin
      cfgQ   <= CFG_RESET;
      ienQ   <= '0;
      txActQ <= '0;
      rxActQ <= '0;
    end else begin
      if (stb.cfgWr) cfgQ <= regWrData & CFG_KEEP;
      if (stb.ienWr) ienQ <= regWrData[IEN_W-1:0];
      if (stb.txSet)      txActQ <= txActQ | txActWr;
      else if (stb.txClr) txActQ <= txActQ & ~txActWr;
      if (stb.rxSet)      rxActQ <= rxActQ | rxActWr;
      else if (stb.rxClr) rxActQ <= rxActQ & ~rxActWr;
    end
  end

  dmaregs_w1c #(.W(TX_CH)) u_txEob (.clk(clk), .rstN(rstN), .softRst(stb.softRst),
    .clrEn(stb.txEobClr), .clrMask(regWrData[TX_CH-1:0]), .setEvt(txEobEvt), .q(txEobQ));
  dmaregs_w1c #(.W(TX_CH)) u_txDerr (.clk(clk), .rstN(rstN), .softRst(stb.softRst),
    .clrEn(stb.txDerrClr), .clrMask(regWrData[TX_CH-1:0]), .setEvt(txDerrEvt), .q(txDerrQ));
  dmaregs_w1c #(.W(RX_CH)) u_rxEob (.clk(clk), .rstN(rstN), .softRst(stb.softRst),
    .clrEn(stb.rxEobClr), .clrMask(regWrData[RX_CH-1:0]), .setEvt(rxEobEvt), .q(rxEobQ));
  dmaregs_w1c #(.W(RX_CH)) u_rxDerr (.clk(clk), .rstN(rstN), .softRst(stb.softRst),
    .clrEn(stb.rxDerrClr), .clrMask(regWrData[RX_CH-1:0]), .setEvt(rxDerrEvt), .q(rxDerrQ));
  dmaregs_w1c #(.W(ERR_BITS)) u_err (.clk(clk), .rstN(rstN), .softRst(stb.softRst),
    .clrEn(stb.errClr), .clrMask(regWrData[ERR_BITS-1:0]), .setEvt(errEvt), .q(errQ));

  // per-channel pointer and size registers, zero view above the channel count
  for (genvar c = 0; c < MAX_CH; c++) begin : g_chan
    if (c < TX_CH) begin : g_tx
      logic [DATA_W-1:0] ptrQ;
      always_ff @(posedge clk) begin
        if (!rstN) ptrQ <= '0;
        else if (stb.txPtrWr && stb.chan == 5'(c)) ptrQ <= regWrData;
      end
      assign txPtr[c] = ptrQ;
    end else begin : g_txNone
      assign txPtr[c] = '0;
    end
    if (c < RX_CH) begin : g_rx
      logic [DATA_W-1:0] ptrQ;
      logic [7:0]        bsQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ptrQ <= '0;
          bsQ  <= '0;
        end else begin
          if (stb.rxPtrWr && stb.chan == 5'(c)) ptrQ <= regWrData;
          if (stb.rxBsWr && stb.chan == 5'(c))  bsQ  <= regWrData[7:0];
        end
      end
      assign rxPtr[c] = ptrQ;
      assign rxBs[c]  = bsQ;
    end else begin : g_rxNone
      assign rxPtr[c] = '0;
      assign rxBs[c]  = '0;
    end
  end

  always_comb begin
    regRdData = '0;
    case (stb.rdSel)
      RD_CFG:    regRdData = cfgQ;
      RD_ERR:    regRdData[ERR_BITS-1:0] = errQ;
      RD_IEN:    regRdData[IEN_W-1:0] = ienQ;
      RD_TXACT:  for (int c = 0; c < TX_CH; c++) regRdData[DATA_W-1-c] = txActQ[c];
      RD_RXACT:  for (int c = 0; c < RX_CH; c++) regRdData[DATA_W-1-c] = rxActQ[c];
      RD_TXEOB:  regRdData[TX_CH-1:0] = txEobQ;
      RD_RXEOB:  regRdData[RX_CH-1:0] = rxEobQ;
      RD_TXDERR: regRdData[TX_CH-1:0] = txDerrQ;
      RD_RXDERR: regRdData[RX_CH-1:0] = rxDerrQ;
      RD_TXPTR:  regRdData = txPtr[stb.chan];
      RD_RXPTR:  regRdData = rxPtr[stb.chan];
      RD_RXBS:   regRdData[7:0] = rxBs[stb.chan];
      default:   regRdData = '0;
    endcase
  end

  assign irq[0] = ienQ[0] && (|txEobQ);
  assign irq[1] = ienQ[1] && (|rxEobQ);
  assign irq[2] = (ienQ[2] && (|txDerrQ)) || (ienQ[4] && (|rxDerrQ));
  assign irq[3] = ienQ[3] && (|errQ);

  p_cfg_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr |=> cfgQ == ($past(regWrData) & CFG_KEEP));

  p_soft_reset_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (cfgQ == CFG_RESET && ienQ == '0 && txActQ == '0 &&
                     rxActQ == '0 && txEobQ == '0 && errQ == '0 && irq == 4'b0));

  p_act_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txSet && !stb.softRst) |=> ((txActQ & $past(txActWr)) == $past(txActWr)));

  p_act_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.txClr |=> ((txActQ & $past(txActWr)) == '0));

  p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txEobEvt != '0 && ienQ[0] && !stb.softRst && !stb.ienWr) |=> irq[0]);
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs #(
  parameter int TX_CH    = 4,
  parameter int RX_CH    = 2,
  parameter int ERR_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [9:0]          regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [TX_CH-1:0]    txEobEvt,
  input  logic [TX_CH-1:0]    txDerrEvt,
  input  logic [RX_CH-1:0]    rxEobEvt,
  input  logic [RX_CH-1:0]    rxDerrEvt,
  input  logic [ERR_BITS-1:0] errEvt,
  output logic [3:0]          irq
);
  dmaregs_pkg::strobes_t stb;

  dmaregs_decode #(.TX_CH(TX_CH), .RX_CH(RX_CH)) u_decode (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .stb      (stb)
  );

  dmaregs_datapath #(.TX_CH(TX_CH), .RX_CH(RX_CH), .ERR_BITS(ERR_BITS)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regWrData(regWrData),
    .txEobEvt (txEobEvt),
    .txDerrEvt(txDerrEvt),
    .rxEobEvt (rxEobEvt),
    .rxDerrEvt(rxDerrEvt),
    .errEvt   (errEvt),
    .regRdData(regRdData),
    .irq      (irq)
  );
endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  localparam int TXN = 4;
  localparam int RXN = 2;
  localparam int ERN = 8;
  localparam int CLK_NS = 10;

  localparam logic [9:0] CFG = 10'h180, ERR = 10'h181, IEN = 10'h182;
  localparam logic [9:0] TXS = 10'h188, TXC = 10'h189, RXS = 10'h18A, RXC = 10'h18B;
  localparam logic [9:0] TXE = 10'h18C, RXE = 10'h18D, TXD = 10'h18E, RXD = 10'h18F;

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [TXN-1:0] tEob = '0, tDerr = '0;
  logic [RXN-1:0] rEob = '0, rDerr = '0;
  logic [ERN-1:0] eEvt = '0;
  logic [3:0] irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  logic [31:0] mCfg;
  logic [4:0]  mIen;
  logic [ERN-1:0] mErr;
  logic [TXN-1:0] mTxAct, mTxEob, mTxDerr;
  logic [RXN-1:0] mRxAct, mRxEob, mRxDerr;
  logic [31:0] mTxPtr [TXN];
  logic [31:0] mRxPtr [RXN];
  logic [7:0]  mBs [RXN];

  dma_chan_regs #(.TX_CH(TXN), .RX_CH(RXN), .ERR_BITS(ERN)) i_dma_chan_regs (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regAddr(addr), .regWrData(wdata),
    .regRdData(rdata), .txEobEvt(tEob), .txDerrEvt(tDerr), .rxEobEvt(rEob),
    .rxDerrEvt(rDerr), .errEvt(eEvt), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic void softModel();
    mCfg = 32'h0007_C000; mIen = '0; mErr = '0;
    mTxAct = '0; mTxEob = '0; mTxDerr = '0;
    mRxAct = '0; mRxEob = '0; mRxDerr = '0;
  endfunction

  function automatic void hardModel();
    softModel();
    for (int c = 0; c < TXN; c++) mTxPtr[c] = '0;
    for (int c = 0; c < RXN; c++) begin mRxPtr[c] = '0; mBs[c] = '0; end
  endfunction

  function automatic void modelStep(input logic wr, input logic [9:0] a, input logic [31:0] d,
      input logic [TXN-1:0] te, input logic [TXN-1:0] td, input logic [RXN-1:0] re,
      input logic [RXN-1:0] rd, input logic [ERN-1:0] ee);
    if (wr && a == CFG && d[31]) begin softModel(); return; end
    if (wr) begin
      case (a)
        CFG: mCfg = d & 32'h00FF_C087;
        ERR: mErr = mErr & ~d[ERN-1:0];
        IEN: mIen = d[4:0];
        TXS: for (int c = 0; c < TXN; c++) if (d[31-c]) mTxAct[c] = 1'b1;
        TXC: for (int c = 0; c < TXN; c++) if (d[31-c]) mTxAct[c] = 1'b0;
        RXS: for (int c = 0; c < RXN; c++) if (d[31-c]) mRxAct[c] = 1'b1;
        RXC: for (int c = 0; c < RXN; c++) if (d[31-c]) mRxAct[c] = 1'b0;
        TXE: mTxEob  = mTxEob  & ~d[TXN-1:0];
        RXE: mRxEob  = mRxEob  & ~d[RXN-1:0];
        TXD: mTxDerr = mTxDerr & ~d[TXN-1:0];
        RXD: mRxDerr = mRxDerr & ~d[RXN-1:0];
        default: begin
          if (a >= 10'h1A0 && a < 10'h1A0 + TXN) mTxPtr[a - 10'h1A0] = d;
          if (a >= 10'h1C0 && a < 10'h1C0 + RXN) mRxPtr[a - 10'h1C0] = d;
          if (a >= 10'h1E0 && a < 10'h1E0 + RXN) mBs[a - 10'h1E0] = d[7:0];
        end
      endcase
    end
    mTxEob |= te; mTxDerr |= td; mRxEob |= re; mRxDerr |= rd; mErr |= ee;
  endfunction

  function automatic logic [31:0] expRead(input logic [9:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      CFG: r = mCfg;
      ERR: r[ERN-1:0] = mErr;
      IEN: r[4:0] = mIen;
      TXS, TXC: for (int c = 0; c < TXN; c++) r[31-c] = mTxAct[c];
      RXS, RXC: for (int c = 0; c < RXN; c++) r[31-c] = mRxAct[c];
      TXE: r[TXN-1:0] = mTxEob;
      RXE: r[RXN-1:0] = mRxEob;
      TXD: r[TXN-1:0] = mTxDerr;
      RXD: r[RXN-1:0] = mRxDerr;
      default: begin
        if (a >= 10'h1A0 && a < 10'h1A0 + TXN) r = mTxPtr[a - 10'h1A0];
        if (a >= 10'h1C0 && a < 10'h1C0 + RXN) r = mRxPtr[a - 10'h1C0];
        if (a >= 10'h1E0 && a < 10'h1E0 + RXN) r[7:0] = mBs[a - 10'h1E0];
      end
    endcase
    return r;
  endfunction

  function automatic logic [3:0] expIrq();
    return {mIen[3] && (|mErr),
            (mIen[2] && (|mTxDerr)) || (mIen[4] && (|mRxDerr)),
            mIen[1] && (|mRxEob),
            mIen[0] && (|mTxEob)};
  endfunction

  task automatic cyc(input logic wr, input logic [9:0] a, input logic [31:0] d,
      input logic [TXN-1:0] te, input logic [TXN-1:0] td, input logic [RXN-1:0] re,
      input logic [RXN-1:0] rd, input logic [ERN-1:0] ee);
    @(negedge clk);
    wrEn = wr; addr = a; wdata = d; tEob = te; tDerr = td; rEob = re; rDerr = rd; eEvt = ee;
    @(posedge clk);
    modelStep(wr, a, d, te, td, re, rd, ee);
    #1;
    wrEn = 0; tEob = '0; tDerr = '0; rEob = '0; rDerr = '0; eEvt = '0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0, '0, '0, '0, '0);
  endtask

  task automatic chk(input logic [9:0] a, input string tag);
    logic [31:0] e;
    addr = a;
    #1;
    e = expRead(a);
    total++;
    if (rdata !== e) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, e);
    end
    total++;
    if (irq !== expIrq()) begin
      bad++;
      $display("FAIL R7 (%s) irq actual=%b expected=%b", tag, irq, expIrq());
    end
  endtask

  task automatic chkAll(input string tag);
    logic [9:0] lst [11];
    lst = '{CFG, ERR, IEN, TXS, TXC, RXS, RXC, TXE, RXE, TXD, RXD};
    foreach (lst[i]) chk(lst[i], tag);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [9:0] regs [11];
    regs = '{CFG, ERR, IEN, TXS, TXC, RXS, RXC, TXE, RXE, TXD, RXD};
    void'($urandom(32'h5EED_0042));
    hardModel();
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: hard reset state
    chkAll("R1 reset");
    chk(10'h1A0, "R1 txptr"); chk(10'h1C1, "R1 rxptr"); chk(10'h1E0, "R1 bufsize");

    // R2: config mask
    wr(CFG, 32'h7FFF_FFFF); chk(CFG, "R2 cfg all ones");
    wr(CFG, 32'h0123_4567); chk(CFG, "R2 cfg pattern");

    // R4: enable keeps five bits
    wr(IEN, 32'hFFFF_FFFF); chk(IEN, "R4 ien");

    // R5: active set/clear
    wr(TXS, 32'hFFFF_FFFF); chk(TXS, "R5 tx set");
    wr(TXC, 32'h5FFF_FFFF); chk(TXC, "R5 tx clear");
    wr(RXS, 32'h4000_0001); chk(RXC, "R5 rx set");
    wr(RXS, 32'h8000_0000); wr(RXC, 32'h4000_0000); chk(RXS, "R5 rx clear");

    // R6/R7: events, clears, same-cycle priority
    cyc(1'b0, '0, '0, 4'b0101, '0, '0, '0, '0); chk(TXE, "R6 tx eob set");
    wr(TXE, 32'h1); chk(TXE, "R6 tx eob clear");
    cyc(1'b1, TXE, 32'h4, 4'b0100, '0, '0, '0, '0); chk(TXE, "R6 clear vs event");
    cyc(1'b0, '0, '0, '0, '0, '0, 2'b10, '0); chk(RXD, "R7 rx derr irq2");
    wr(IEN, 32'h0); chk(TXE, "R7 gated off");
    wr(IEN, 32'h1F);

    // R10: error status
    cyc(1'b0, '0, '0, '0, '0, '0, '0, 8'hA5); chk(ERR, "R10 err set");
    wr(ERR, 32'h0000_0081); chk(ERR, "R10 err clear");

    // R8 / R9: pointer windows
    wr(10'h1A3, 32'hDEAD_BEEF); chk(10'h1A3, "R8 txptr");
    wr(10'h1C1, 32'h1234_5678); chk(10'h1C1, "R8 rxptr");
    wr(10'h1E1, 32'h0000_ABCD); chk(10'h1E1, "R8 bufsize");
    wr(10'h1A4, 32'hFFFF_FFFF); chk(10'h1A4, "R9 tx out of range");
    wr(10'h1C2, 32'hFFFF_FFFF); chk(10'h1C2, "R9 rx out of range");
    wr(10'h1FF, 32'hFFFF_FFFF); chk(10'h1FF, "R9 bufsize out of range");
    chk(10'h183, "R9 unmapped"); chk(10'h000, "R9 unmapped low");

    // R3: soft reset keeps pointers, drops same-cycle events
    cyc(1'b1, CFG, 32'h8000_0000, 4'hF, 4'hF, 2'h3, 2'h3, 8'hFF);
    chkAll("R3 soft reset");
    chk(10'h1A3, "R3 txptr kept"); chk(10'h1E1, "R3 bufsize kept");

    // random phase
    for (int it = 0; it < 600; it++) begin
      logic [9:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick < 6)      a = regs[$urandom_range(0, 10)];
      else if (pick < 9) a = 10'h1A0 + 10'($urandom_range(0, 2) * 32) + 10'($urandom_range(0, 7));
      else               a = 10'($urandom);
      d = $urandom;
      if (a == CFG && $urandom_range(0, 7) != 0) d[31] = 1'b0;
      cyc($urandom_range(0, 3) != 0, a, d,
          ($urandom_range(0, 2) == 0) ? TXN'($urandom) : '0,
          ($urandom_range(0, 3) == 0) ? TXN'($urandom) : '0,
          ($urandom_range(0, 2) == 0) ? RXN'($urandom) : '0,
          ($urandom_range(0, 3) == 0) ? RXN'($urandom) : '0,
          ($urandom_range(0, 3) == 0) ? ERN'($urandom) : '0);
      chk(a, "R6 random access");
      chk(regs[$urandom_range(0, 10)], "R5 random readback");
    end
    chkAll("R6 random final");

    done = 1;
    finishRun();
  end
endmodule